// File: doc/BRIEF.md
# Shift-based approximate Q-value updater

This block performs the value-update step of tabular Q-learning for one table entry per clock. It takes the entry being revised (`q_cur`), the reward just received (`reward`) and the largest value in the row of the next state (`row_max`). From these it computes `Q + a*(r + g*M - Q)`, where `a` is the learning rate and `g` is the discount factor. The table storage, the maximum search and the action policy stay outside the block. The caller presents one operand set with `in_valid` and receives the registered result on `q_new` one clock later.

Neither coefficient goes through a multiplier. Both coefficients are unsigned words with one integer bit and `FRAC` fraction bits, and each is approximated by the sum of its one or two most significant powers of two. Multiplying by such a value needs only one or two arithmetic right shifts and an adder. There are two ways to get the shift amounts. Leading-one detectors can find them in the coefficient words on every cycle. Or, with `use_direct` high, the caller supplies them on dedicated ports. The parameter `TERMS` selects approximation with one term or with two terms. Intermediate sums carry three guard bits, and the final value is clamped to the signed `QW`-bit range.

Top module: `qapprox_updater`

## Requirements
- R1: A coefficient bit at position k from the MSB has weight 2^-k: position 0 is the integer bit and position k is fraction bit k. The first set bit, at position i, turns the product of y by the coefficient into y >>> i (for FRAC=7, word 8'h80 means 1.0 and word 8'h01 means 2^-7).
- R2: With TERMS=2, the second set bit, at position j, adds y >>> j. With TERMS=1 that second term is never added. Word 8'h5A (0.1011010 binary) therefore acts as 0.625 with TERMS=2 and as 0.5 with TERMS=1.
- R3: A coefficient word with no set bit gives a zero product, so alpha=0 gives q_new equal to q_cur. A word with a single set bit adds no second term.
- R4: Every shift is an arithmetic right shift of a signed operand, and the discarded bits are truncated, so the result rounds toward minus infinity (-5 scaled by 0.5 gives -3).
- R5: q_new = sat(Q + A(r + G(M) - Q)), where A and G are the shift approximations of alpha and gamma. All operands are signed QW-bit two's complement, the sums are formed without overflow, and the result is clamped to [-2^(QW-1), 2^(QW-1)-1].
- R6: With use_direct=1 the coefficient words are ignored. For each coefficient, terms bit 0 enables the first shift, at pos_first. Terms bit 1 enables the second shift, at pos_second, but only when bit 0 is also set, pos_second > pos_first and TERMS=2. A coefficient with bit 0 clear gives a zero product.
- R7: out_valid and q_new are updated on the rising edge that samples in_valid=1, one cycle of latency. On a cycle with in_valid=0, out_valid drops to 0 and q_new keeps its value.
- R8: While rst is high (synchronous, active high), out_valid and q_new are held at 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| in_valid | input | 1 | Operand set present this cycle |
| q_cur | input | QW | Signed current value of the entry being updated |
| reward | input | QW | Signed reward |
| row_max | input | QW | Signed maximum of the next-state row |
| alpha | input | FRAC+1 | Learning-rate word, 1 integer bit and FRAC fraction bits |
| gamma | input | FRAC+1 | Discount word, same format |
| use_direct | input | 1 | 1: take shift amounts from the direct ports |
| alpha_pos_first | input | PW | Direct first shift amount for alpha |
| alpha_pos_second | input | PW | Direct second shift amount for alpha |
| alpha_terms | input | 2 | Bit 0 enables the first alpha term, bit 1 enables the second |
| gamma_pos_first | input | PW | Direct first shift amount for gamma |
| gamma_pos_second | input | PW | Direct second shift amount for gamma |
| gamma_terms | input | 2 | Bit 0 enables the first gamma term, bit 1 enables the second |
| out_valid | output | 1 | q_new was written on the last edge |
| q_new | output | QW | Signed updated value, saturated |

## Verification
Every result is due exactly one rising edge after the edge that samples `in_valid` high, because the block holds a single output register and no other state. The bench changes its inputs on falling edges. It reads `q_new` and `out_valid` at the next falling edge, half a period after that rising edge. For the hold check it reads them again one edge later, after `in_valid` has returned low and the operands have changed. Two instances run side by side, one with two-term and one with one-term approximation, so that each operand set shows how the second term changes the result.

// File: rtl/qupd_pkg.sv
package qupd_pkg;

    // Where the shift amounts come from
    typedef enum logic {
        SRC_DETECT = 1'b0,
        SRC_DIRECT = 1'b1
    } shift_src_e;

    // Which of the two power-of-two terms take part
    typedef struct packed {
        logic first;
        logic second;
    } term_use_t;

    // Bits needed to hold a bit position within a word of cw bits
    function automatic int pos_width(input int cw);
        return (cw > 1) ? $clog2(cw) : 1;
    endfunction

endpackage

// File: rtl/qupd_lod.sv
module qupd_lod
    import qupd_pkg::*;
#(
    parameter int CW = 8,
    parameter int PW = 3
) (
    input  logic [CW-1:0] coef,
    output logic [PW-1:0] pos_first,
    output logic [PW-1:0] pos_second,
    output term_use_t     found
);

    // Scan from the MSB (position 0) towards the LSB and keep the first two ones
    always_comb begin
        pos_first  = '0;
        pos_second = '0;
        found      = '0;
        for (int k = 0; k < CW; k++) begin
            if (coef[CW-1-k]) begin
                if (!found.first) begin
                    found.first = 1'b1;
                    pos_first   = PW'(k);
                end else if (!found.second) begin
                    found.second = 1'b1;
                    pos_second   = PW'(k);
                end
            end
        end
    end

endmodule

// File: rtl/qupd_coef_path.sv
module qupd_coef_path
    import qupd_pkg::*;
#(
    parameter int CW    = 8,
    parameter int PW    = 3,
    parameter int TERMS = 2
) (
    input  logic [CW-1:0] coef,
    input  shift_src_e    src,
    input  logic [PW-1:0] dir_first,
    input  logic [PW-1:0] dir_second,
    input  term_use_t     dir_use,
    output logic [PW-1:0] sh_first,
    output logic [PW-1:0] sh_second,
    output term_use_t     terms_on
);

    localparam bit TWO_TERMS = (TERMS >= 2);

    logic [PW-1:0] det_first;
    logic [PW-1:0] det_second;
    term_use_t     det_use;
    term_use_t     raw_use;

    qupd_lod #(.CW(CW), .PW(PW)) u_lod (
        .coef      (coef),
        .pos_first (det_first),
        .pos_second(det_second),
        .found     (det_use)
    );

    always_comb begin
        if (src == SRC_DIRECT) begin
            sh_first       = dir_first;
            sh_second      = dir_second;
            raw_use.first  = dir_use.first;
            // A direct second term must lie strictly below the first one
            raw_use.second = dir_use.first && dir_use.second && (dir_second > dir_first);
        end else begin
            sh_first  = det_first;
            sh_second = det_second;
            raw_use   = det_use;
        end
        terms_on.first  = raw_use.first;
        terms_on.second = raw_use.second && TWO_TERMS;
    end

endmodule

// File: rtl/qupd_shift_mul.sv
module qupd_shift_mul
    import qupd_pkg::*;
#(
    parameter int W  = 19,
    parameter int PW = 3
) (
    input  logic signed [W-1:0] y,
    input  logic [PW-1:0]       sh_first,
    input  logic [PW-1:0]       sh_second,
    input  term_use_t           terms_on,
    output logic signed [W-1:0] prod
);

    logic signed [W-1:0] part_a;
    logic signed [W-1:0] part_b;

    // Arithmetic shifts: the discarded low bits are dropped (floor)
    always_comb begin
        if (terms_on.first) part_a = y >>> sh_first;
        else                part_a = '0;
        if (terms_on.second) part_b = y >>> sh_second;
        else                 part_b = '0;
        prod = part_a + part_b;
    end

endmodule

// File: rtl/qapprox_updater.sv
module qapprox_updater
    import qupd_pkg::*;
#(
    parameter int QW    = 16,
    parameter int FRAC  = 7,
    parameter int TERMS = 2,
    localparam int CW   = FRAC + 1,
    localparam int PW   = pos_width(FRAC + 1)
) (
    input  logic                 clk,
    input  logic                 rst,
    input  logic                 in_valid,
    input  logic signed [QW-1:0] q_cur,
    input  logic signed [QW-1:0] reward,
    input  logic signed [QW-1:0] row_max,
    input  logic [CW-1:0]        alpha,
    input  logic [CW-1:0]        gamma,
    input  logic                 use_direct,
    input  logic [PW-1:0]        alpha_pos_first,
    input  logic [PW-1:0]        alpha_pos_second,
    input  logic [1:0]           alpha_terms,
    input  logic [PW-1:0]        gamma_pos_first,
    input  logic [PW-1:0]        gamma_pos_second,
    input  logic [1:0]           gamma_terms,
    output logic                 out_valid,
    output logic signed [QW-1:0] q_new
);

    // Three guard bits cover coefficients up to 1.5 and a three-operand error
    localparam int XW        = QW + 3;
    localparam int NCOEF     = 2;
    localparam int IDX_ALPHA = 0;
    localparam int IDX_GAMMA = 1;
    localparam logic signed [XW-1:0] SAT_HI = XW'((64'sd1 <<< (QW - 1)) - 64'sd1);
    localparam logic signed [XW-1:0] SAT_LO = ~SAT_HI;

    // ---------------- coefficient paths ----------------
    shift_src_e    src;
    logic [CW-1:0] coef_w   [NCOEF];
    logic [PW-1:0] dir_a    [NCOEF];
    logic [PW-1:0] dir_b    [NCOEF];
    term_use_t     dir_on   [NCOEF];
    logic [PW-1:0] shift_a  [NCOEF];
    logic [PW-1:0] shift_b  [NCOEF];
    term_use_t     live_on  [NCOEF];

    assign src = use_direct ? SRC_DIRECT : SRC_DETECT;

    assign coef_w[IDX_ALPHA] = alpha;
    assign coef_w[IDX_GAMMA] = gamma;
    assign dir_a[IDX_ALPHA]  = alpha_pos_first;
    assign dir_a[IDX_GAMMA]  = gamma_pos_first;
    assign dir_b[IDX_ALPHA]  = alpha_pos_second;
    assign dir_b[IDX_GAMMA]  = gamma_pos_second;
    assign dir_on[IDX_ALPHA] = '{first: alpha_terms[0], second: alpha_terms[1]};
    assign dir_on[IDX_GAMMA] = '{first: gamma_terms[0], second: gamma_terms[1]};

    generate
        for (genvar c = 0; c < NCOEF; c++) begin : g_coef
            qupd_coef_path #(.CW(CW), .PW(PW), .TERMS(TERMS)) u_path (
                .coef      (coef_w[c]),
                .src       (src),
                .dir_first (dir_a[c]),
                .dir_second(dir_b[c]),
                .dir_use   (dir_on[c]),
                .sh_first  (shift_a[c]),
                .sh_second (shift_b[c]),
                .terms_on  (live_on[c])
            );
        end
    endgenerate

    // ---------------- datapath ----------------
    logic signed [XW-1:0] q_x;
    logic signed [XW-1:0] r_x;
    logic signed [XW-1:0] m_x;
    logic signed [XW-1:0] disc_m;
    logic signed [XW-1:0] err_x;
    logic signed [XW-1:0] step_x;
    logic signed [XW-1:0] sum_x;
    logic signed [QW-1:0] q_sat;

    assign q_x = XW'(q_cur);
    assign r_x = XW'(reward);
    assign m_x = XW'(row_max);

    qupd_shift_mul #(.W(XW), .PW(PW)) u_gamma_mul (
        .y        (m_x),
        .sh_first (shift_a[IDX_GAMMA]),
        .sh_second(shift_b[IDX_GAMMA]),
        .terms_on (live_on[IDX_GAMMA]),
        .prod     (disc_m)
    );

    assign err_x = r_x + disc_m - q_x;

    qupd_shift_mul #(.W(XW), .PW(PW)) u_alpha_mul (
        .y        (err_x),
        .sh_first (shift_a[IDX_ALPHA]),
        .sh_second(shift_b[IDX_ALPHA]),
        .terms_on (live_on[IDX_ALPHA]),
        .prod     (step_x)
    );

    assign sum_x = q_x + step_x;

    always_comb begin
        if (sum_x > SAT_HI)      q_sat = SAT_HI[QW-1:0];
        else if (sum_x < SAT_LO) q_sat = SAT_LO[QW-1:0];
        else                     q_sat = sum_x[QW-1:0];
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            out_valid <= 1'b0;
            q_new     <= '0;
        end else begin
            out_valid <= in_valid;
            if (in_valid) q_new <= q_sat;
        end
    end

    // ---------------- assertions ----------------
    // R7
    valid_lat_chk: assert property (@(posedge clk) disable iff (rst)
        in_valid |=> out_valid);

    // R7
    hold_idle_chk: assert property (@(posedge clk) disable iff (rst)
        !in_valid |=> (!out_valid && $stable(q_new)));

    // R3
    alpha_zero_chk: assert property (@(posedge clk) disable iff (rst)
        (in_valid && !use_direct && alpha == '0) |=> (q_new == $past(q_cur)));

    // R6
    pick_order_chk: assert property (@(posedge clk) disable iff (rst)
        live_on[IDX_ALPHA].second |-> (live_on[IDX_ALPHA].first && shift_b[IDX_ALPHA] > shift_a[IDX_ALPHA]));

    // R8
    reset_clear_chk: assert property (@(posedge clk) disable iff (rst)
        $fell(rst) |-> (!out_valid && q_new == '0));

endmodule

// File: tb/tb_qapprox_updater.sv
module tb_qapprox_updater;

    localparam int CLK_PERIOD = 10;
    localparam int QW   = 16;
    localparam int FRAC = 7;
    localparam int CW   = FRAC + 1;
    localparam int PW   = 3;

    logic                 clk = 1'b0;
    logic                 rst = 1'b1;
    logic                 in_valid = 1'b0;
    logic signed [QW-1:0] q_cur = '0;
    logic signed [QW-1:0] reward = '0;
    logic signed [QW-1:0] row_max = '0;
    logic [CW-1:0]        alpha = '0;
    logic [CW-1:0]        gamma = '0;
    logic                 use_direct = 1'b0;
    logic [PW-1:0]        alpha_pos_first = '0;
    logic [PW-1:0]        alpha_pos_second = '0;
    logic [1:0]           alpha_terms = '0;
    logic [PW-1:0]        gamma_pos_first = '0;
    logic [PW-1:0]        gamma_pos_second = '0;
    logic [1:0]           gamma_terms = '0;
    logic                 v2, v1;
    logic signed [QW-1:0] q2, q1;

    int n_checks = 0;
    int n_fail   = 0;
    bit finished = 1'b0;

    always #(CLK_PERIOD/2) clk = ~clk;

    qapprox_updater #(.QW(QW), .FRAC(FRAC), .TERMS(2)) dut (
        .clk(clk), .rst(rst), .in_valid(in_valid),
        .q_cur(q_cur), .reward(reward), .row_max(row_max),
        .alpha(alpha), .gamma(gamma), .use_direct(use_direct),
        .alpha_pos_first(alpha_pos_first), .alpha_pos_second(alpha_pos_second), .alpha_terms(alpha_terms),
        .gamma_pos_first(gamma_pos_first), .gamma_pos_second(gamma_pos_second), .gamma_terms(gamma_terms),
        .out_valid(v2), .q_new(q2)
    );

    qapprox_updater #(.QW(QW), .FRAC(FRAC), .TERMS(1)) dut_one (
        .clk(clk), .rst(rst), .in_valid(in_valid),
        .q_cur(q_cur), .reward(reward), .row_max(row_max),
        .alpha(alpha), .gamma(gamma), .use_direct(use_direct),
        .alpha_pos_first(alpha_pos_first), .alpha_pos_second(alpha_pos_second), .alpha_terms(alpha_terms),
        .gamma_pos_first(gamma_pos_first), .gamma_pos_second(gamma_pos_second), .gamma_terms(gamma_terms),
        .out_valid(v1), .q_new(q1)
    );

    // ---------- reference model built from the requirements ----------
    function automatic longint coef_mul(input longint y, input logic [CW-1:0] c, input bit dir,
                                        input int p1d, input int p2d, input logic [1:0] tf, input int terms);
        int p1 = -1;
        int p2 = -1;
        longint res = 0;
        if (dir) begin
            if (tf[0]) begin
                p1 = p1d;
                if (tf[1] && p2d > p1d) p2 = p2d;
            end
        end else begin
            for (int k = 0; k < CW; k++) begin
                if (c[CW-1-k]) begin
                    if (p1 < 0) p1 = k;
                    else if (p2 < 0) p2 = k;
                end
            end
        end
        if (terms < 2) p2 = -1;
        if (p1 >= 0) res += (y >>> p1);
        if (p2 >= 0) res += (y >>> p2);
        return res;
    endfunction

    function automatic longint expect_q(input longint q, input longint r, input longint m, input int terms);
        longint e;
        longint s;
        e = r + coef_mul(m, gamma, use_direct, int'(gamma_pos_first), int'(gamma_pos_second), gamma_terms, terms) - q;
        s = q + coef_mul(e, alpha, use_direct, int'(alpha_pos_first), int'(alpha_pos_second), alpha_terms, terms);
        if (s > 32767)  s = 32767;
        if (s < -32768) s = -32768;
        return s;
    endfunction

    task automatic check(input string req, input string what, input longint act, input longint exp);
        n_checks++;
        if (act !== exp) begin
            n_fail++;
            $display("FAIL %s %s: actual %0d expected %0d", req, what, act, exp);
        end
    endtask

    // Drive one operand set for one cycle; the result is read half a period after the capturing edge
    task automatic pulse(input longint q, input longint r, input longint m,
                         input logic [CW-1:0] a, input logic [CW-1:0] g);
        @(negedge clk);
        q_cur    = QW'(q);
        reward   = QW'(r);
        row_max  = QW'(m);
        alpha    = a;
        gamma    = g;
        in_valid = 1'b1;
        @(negedge clk);
        in_valid = 1'b0;
    endtask

    task automatic run_model(input string req, input longint q, input longint r, input longint m,
                             input logic [CW-1:0] a, input logic [CW-1:0] g);
        pulse(q, r, m, a, g);
        check(req, "valid", v2, 1);
        check(req, "two-term model", q2, expect_q(q, r, m, 2));
        check(req, "one-term model", q1, expect_q(q, r, m, 1));
    endtask

    // ---------- scenarios ----------
    task automatic t_reset();
        repeat (3) @(negedge clk);
        check("R8", "out_valid in reset", v2, 0);
        check("R8", "q_new in reset", q2, 0);
        check("R8", "one-term q_new in reset", q1, 0);
        rst = 1'b0;
    endtask

    task automatic t_terms();
        pulse(0, 800, 0, 8'h5A, 8'h00);
        check("R2", "0x5A two terms", q2, 500);
        check("R2", "0x5A one term", q1, 400);
        pulse(0, 800, 0, 8'h80, 8'h00);
        check("R1", "alpha 1.0", q2, 800);
        pulse(0, 1280, 0, 8'h01, 8'h00);
        check("R1", "alpha lsb", q2, 10);
        check("R1", "alpha lsb one term", q1, 10);
    endtask

    task automatic t_zero();
        pulse(1234, -5000, 7000, 8'h00, 8'h5A);
        check("R3", "alpha zero", q2, 1234);
        check("R3", "alpha zero one term", q1, 1234);
        pulse(0, 0, 1000, 8'h80, 8'h40);
        check("R3", "single-one gamma", q2, 500);
        check("R3", "single-one gamma one term", q1, 500);
    endtask

    task automatic t_floor();
        pulse(0, -5, 0, 8'h40, 8'h00);
        check("R4", "negative floor", q2, -3);
        pulse(0, 5, 0, 8'h40, 8'h00);
        check("R4", "positive floor", q2, 2);
    endtask

    task automatic t_sat();
        pulse(-32768, 32767, 32767, 8'h80, 8'h80);
        check("R5", "positive clamp", q2, 32767);
        pulse(32767, -32768, -32768, 8'h80, 8'h80);
        check("R5", "negative clamp", q2, -32768);
        pulse(100, 50, 200, 8'h5A, 8'h60);
        check("R5", "mixed two terms", q2, 162);
        check("R5", "mixed one term", q1, 125);
    endtask

    task automatic t_direct();
        use_direct       = 1'b1;
        alpha_pos_first  = 3'd1;
        alpha_pos_second = 3'd2;
        alpha_terms      = 2'b11;
        gamma_terms      = 2'b00;
        pulse(0, 400, 1000, 8'h00, 8'h80);
        check("R6", "direct two terms", q2, 300);
        check("R6", "direct one term", q1, 200);
        alpha_pos_first  = 3'd2;
        alpha_pos_second = 3'd1;
        pulse(0, 400, 1000, 8'h00, 8'h80);
        check("R6", "second above first dropped", q2, 100);
        alpha_terms = 2'b10;
        pulse(77, 400, 1000, 8'hFF, 8'h80);
        check("R6", "first disabled", q2, 77);
        use_direct  = 1'b0;
        alpha_terms = 2'b00;
    endtask

    task automatic t_latency();
        @(negedge clk);
        q_cur = 16'sd10; reward = 16'sd30; row_max = 16'sd0;
        alpha = 8'h80; gamma = 8'h00; in_valid = 1'b1;
        @(posedge clk);
        #1;
        check("R7", "valid one edge later", v2, 1);
        check("R7", "value one edge later", q2, 30);
        @(negedge clk);
        in_valid = 1'b0;
        reward   = 16'sd999;
        q_cur    = -16'sd444;
        @(negedge clk);
        check("R7", "valid drops when idle", v2, 0);
        check("R7", "value held when idle", q2, 30);
    endtask

    task automatic t_sweep();
        logic [31:0] s = 32'h1234_5678;
        for (int n = 0; n < 40; n++) begin
            longint q, r, m;
            logic [CW-1:0] a, g;
            s = s ^ (s << 13); s = s ^ (s >> 17); s = s ^ (s << 5);
            q = longint'($signed(s[15:0]));
            a = s[23:16];
            s = s ^ (s << 13); s = s ^ (s >> 17); s = s ^ (s << 5);
            r = longint'($signed(s[15:0]));
            g = s[23:16];
            s = s ^ (s << 13); s = s ^ (s >> 17); s = s ^ (s << 5);
            m = longint'($signed(s[15:0]));
            use_direct       = s[16];
            alpha_pos_first  = s[19:17];
            alpha_pos_second = s[22:20];
            alpha_terms      = s[24:23];
            gamma_pos_first  = s[27:25];
            gamma_pos_second = s[30:28];
            gamma_terms      = {s[31], s[16] ^ s[31]};
            run_model("R5", q, r, m, a, g);
        end
        use_direct = 1'b0;
    endtask

    // ---------- main ----------
    initial begin
        t_reset();
        t_terms();
        t_zero();
        t_floor();
        t_sat();
        t_direct();
        t_latency();
        t_sweep();
        finished = 1'b1;
        $display("End of test - %0d assertions evaluated, %0d failures", n_checks, n_fail);
        $finish;
    end

    initial begin
        #(CLK_PERIOD * 50000);
        if (!finished) begin
            n_fail++;
            $display("FAIL watchdog: actual timeout expected completion");
            $display("End of test - %0d assertions evaluated, %0d failures", n_checks, n_fail);
            $finish;
        end
    end

endmodule